// File: doc/BRIEF.md
# Coalesced Interrupt EOI Tracker

This block sits beside one edge-triggered interrupt pin and keeps a record of every destination that took that pin's last tracked interrupt, together with the vector each destination was given. It counts the destinations that have not yet sent an end-of-interrupt (EOI). While that count is above zero, a new tracked assertion of the pin is flagged as coalesced, so the caller can drop the edge and report it rather than deliver it again. An untracked assertion is never flagged.

The delivery logic reports each delivery's result on the block's delivery port: the set of accepting destinations and the vector that was sent. The local interrupt controllers report EOIs, one destination per cycle. Two resynchronisation paths keep the record in line with the destinations' live pending state. A single-destination resync corrects one entry. A full rebuild clears everything and then walks every destination, one per cycle, reading a live pending bitmap. The full rebuild also starts on its own if a decrement would take the count below zero.

The controller has three states. IDLE accepts events. CLEAR wipes the map and the count. SCAN visits destination 0 to NUM_DEST-1, one per cycle. The transitions are:
- IDLE→CLEAR on a rebuild request or on an underflowing decrement.
- CLEAR→SCAN always.
- SCAN→SCAN while the index is below NUM_DEST-1.
- SCAN→IDLE after the last destination.

Top module: `eoi_coalesce_tracker`

## Requirements
- R1: After reset the pending count is 0, every destination's bit is clear, `busy` is 0, and `coalesced` is 0 even when a tracked assertion is presented.
- R2: `coalesced` is 1 exactly when `edge_valid` and `edge_track` are both 1 and the pending count is above zero. An assertion with `edge_track` at 0 is never coalesced.
- R3: A tracked delivery (`dlv_valid` and `dlv_track` both 1) replaces the map with `dlv_map` (bit i set means destination i accepted). It records `dlv_vec` for each accepting destination. From the next cycle the count equals the number of ones in `dlv_map`, so an empty map gives 0.
- R4: A delivery with `dlv_track` at 0 changes neither the map nor the count.
- R5: An EOI naming a destination whose bit is set, and carrying that destination's recorded vector, clears the bit and lowers the count by one on the next cycle.
- R6: An EOI naming a destination whose bit is clear, or carrying a different vector, has no effect.
- R7: A single resync (`sync_valid`) compares `sync_pend` with the named destination's bit. If they differ, it sets the bit (recording `sync_vec`) and adds one, or clears the bit and subtracts one. If they agree, nothing changes.
- R8: A rebuild request raises `busy` on the next cycle. The block then spends one cycle clearing and NUM_DEST cycles scanning, and `busy` falls NUM_DEST+1 cycles after it rose. At that point the map equals `live_pend`, each set destination holds `live_vec`, and the count is the number of ones in `live_pend`. Delivery, EOI and resync inputs are ignored while `busy` is 1.
- R9: In IDLE only one event is taken per cycle. The priority is rebuild request, then delivery (tracked or not), then EOI, then resync. Lower-priority strobes in the same cycle are discarded.
- R10: The count never wraps and never exceeds NUM_DEST. A decrement at zero is not applied and starts a rebuild instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_valid | input | 1 | The tracked pin is asserting this cycle |
| edge_track | input | 1 | Line-status enable for this assertion |
| coalesced | output | 1 | Assertion must be reported as coalesced |
| dlv_valid | input | 1 | Delivery result strobe |
| dlv_track | input | 1 | Line-status enable for the delivery |
| dlv_map | input | NUM_DEST | Destinations that accepted the delivery |
| dlv_vec | input | VEC_W | Vector that was delivered |
| eoi_valid | input | 1 | EOI strobe |
| eoi_dest | input | DIDX_W | Destination that sent the EOI |
| eoi_vec | input | VEC_W | Vector the EOI acknowledges |
| sync_valid | input | 1 | Single-destination resync strobe |
| sync_dest | input | DIDX_W | Destination being resynchronised |
| sync_pend | input | 1 | Live pending status of that destination |
| sync_vec | input | VEC_W | Vector pending at that destination |
| rebuild_req | input | 1 | Request a full rebuild |
| live_pend | input | NUM_DEST | Live pending status of every destination |
| live_vec | input | VEC_W | Vector recorded during a rebuild |
| pend_count | output | CNT_W | Outstanding acknowledgements |
| busy | output | 1 | Rebuild in progress |

## Verification
A wrong map entry or recorded vector stays invisible until an EOI or a resync touches that destination. It then shows as a count that fails to drop, or that drops when it should not, one cycle after the event. From then on `coalesced` gives the wrong answer for every tracked assertion until a new delivery or rebuild overwrites the record. A wrong count shows at `pend_count` one cycle after the event that caused it. A fault in the rebuild walk shows as a wrong `busy` length or as a final count that differs from the population of `live_pend`. The bench therefore checks the count after every event and follows each EOI stream long enough to drain the record.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_SCAN  = 2'd2
    } trk_state_e;

endpackage

// File: rtl/eoi_dest_slot.sv
module eoi_dest_slot #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set,
    input  logic             drop,
    input  logic [VEC_W-1:0] vec_in,
    output logic             pend_o,
    output logic [VEC_W-1:0] vec_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= 1'b0;
            vec_o  <= '0;
        end else if (clr) begin
            pend_o <= 1'b0;
        end else if (set) begin
            pend_o <= 1'b1;
            vec_o  <= vec_in;
        end else if (drop) begin
            pend_o <= 1'b0;
        end
    end

endmodule

// File: rtl/eoi_pend_counter.sv
module eoi_pend_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             underflow
);

    assign underflow = dec && (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end else if (dec && !underflow) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/eoi_coalesce_tracker.sv
module eoi_coalesce_tracker
    import eoi_trk_pkg::*;
#(
    parameter int NUM_DEST = 16,
    parameter int VEC_W    = 8,
    parameter int DIDX_W   = (NUM_DEST > 1) ? $clog2(NUM_DEST) : 1,
    parameter int CNT_W    = $clog2(NUM_DEST + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                edge_valid,
    input  logic                edge_track,
    output logic                coalesced,
    input  logic                dlv_valid,
    input  logic                dlv_track,
    input  logic [NUM_DEST-1:0] dlv_map,
    input  logic [VEC_W-1:0]    dlv_vec,
    input  logic                eoi_valid,
    input  logic [DIDX_W-1:0]   eoi_dest,
    input  logic [VEC_W-1:0]    eoi_vec,
    input  logic                sync_valid,
    input  logic [DIDX_W-1:0]   sync_dest,
    input  logic                sync_pend,
    input  logic [VEC_W-1:0]    sync_vec,
    input  logic                rebuild_req,
    input  logic [NUM_DEST-1:0] live_pend,
    input  logic [VEC_W-1:0]    live_vec,
    output logic [CNT_W-1:0]    pend_count,
    output logic                busy
);

    localparam logic [DIDX_W-1:0] LAST_IDX = DIDX_W'(NUM_DEST - 1);

    trk_state_e          state_q, state_d;
    logic [DIDX_W-1:0]   scan_idx;
    logic [NUM_DEST-1:0] track_map;
    logic [VEC_W-1:0]    slot_vec [NUM_DEST];
    logic [NUM_DEST-1:0] slot_clr, slot_set, slot_drop;
    logic [VEC_W-1:0]    vec_mux;
    logic [CNT_W-1:0]    dlv_pop;
    logic                in_idle, in_scan;
    logic                do_dlv, do_eoi, do_sync, eoi_hit, sync_diff;
    logic                cnt_inc, cnt_dec, cnt_uflow;

    // ---- event decode (IDLE priority: rebuild > delivery > EOI > resync)
    assign in_idle   = (state_q == ST_IDLE);
    assign in_scan   = (state_q == ST_SCAN);
    assign eoi_hit   = track_map[eoi_dest] && (slot_vec[eoi_dest] == eoi_vec);
    assign sync_diff = (sync_pend != track_map[sync_dest]);
    assign do_dlv    = in_idle && !rebuild_req && dlv_valid && dlv_track;
    assign do_eoi    = in_idle && !rebuild_req && !dlv_valid && eoi_valid && eoi_hit;
    assign do_sync   = in_idle && !rebuild_req && !dlv_valid && !eoi_valid
                       && sync_valid && sync_diff;

    always_comb begin
        dlv_pop = '0;
        for (int i = 0; i < NUM_DEST; i++) begin
            dlv_pop = dlv_pop + CNT_W'(dlv_map[i]);
        end
    end

    always_comb begin
        if (do_dlv)       vec_mux = dlv_vec;
        else if (in_scan) vec_mux = live_vec;
        else              vec_mux = sync_vec;
    end

    // ---- per-destination record
    generate
        for (genvar g = 0; g < NUM_DEST; g++) begin : g_slot
            localparam logic [DIDX_W-1:0] IDX = DIDX_W'(g);

            assign slot_clr[g]  = (state_q == ST_CLEAR) || (do_dlv && !dlv_map[g]);
            assign slot_set[g]  = (do_dlv && dlv_map[g])
                                || (do_sync && sync_pend && sync_dest == IDX)
                                || (in_scan && scan_idx == IDX && live_pend[g]);
            assign slot_drop[g] = (do_eoi && eoi_dest == IDX)
                                || (do_sync && !sync_pend && sync_dest == IDX);

            eoi_dest_slot #(.VEC_W(VEC_W)) u_slot (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (slot_clr[g]),
                .set    (slot_set[g]),
                .drop   (slot_drop[g]),
                .vec_in (vec_mux),
                .pend_o (track_map[g]),
                .vec_o  (slot_vec[g])
            );
        end
    endgenerate

    // ---- outstanding count
    assign cnt_inc = (do_sync && sync_pend) || (in_scan && live_pend[scan_idx]);
    assign cnt_dec = do_eoi || (do_sync && !sync_pend);

    eoi_pend_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state_q == ST_CLEAR),
        .load      (do_dlv),
        .load_val  (dlv_pop),
        .inc       (cnt_inc),
        .dec       (cnt_dec),
        .cnt       (pend_count),
        .underflow (cnt_uflow)
    );

    // ---- state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            scan_idx <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR)  scan_idx <= '0;
            else if (in_scan)         scan_idx <= scan_idx + 1'b1;
        end
    end

    // ---- next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rebuild_req || cnt_uflow) state_d = ST_CLEAR;
            ST_CLEAR: state_d = ST_SCAN;
            ST_SCAN:  if (scan_idx == LAST_IDX) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---- outputs
    always_comb begin
        busy      = !in_idle;
        coalesced = edge_valid && edge_track && (pend_count != '0);
    end

endmodule

// File: rtl/eoi_tracker_checker.sv
module eoi_tracker_checker #(
    parameter int NUM_DEST = 16,
    parameter int DIDX_W   = 4,
    parameter int CNT_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                coalesced,
    input logic                dlv_valid,
    input logic                dlv_track,
    input logic [NUM_DEST-1:0] dlv_map,
    input logic                eoi_valid,
    input logic [DIDX_W-1:0]   eoi_dest,
    input logic                rebuild_req,
    input logic [CNT_W-1:0]    pend_count,
    input logic [NUM_DEST-1:0] track_map
);

    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (pend_count == '0 && track_map == '0 && !busy));

    p_coalesced_needs_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
        coalesced |-> (track_map != '0));

    p_count_is_map_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (int'(pend_count) == $countones(track_map)));

    p_tracked_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rebuild_req && dlv_valid && dlv_track)
        |=> (int'(pend_count) == $countones($past(dlv_map))));

    p_untracked_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rebuild_req && dlv_valid && !dlv_track)
        |=> ($stable(pend_count) && $stable(track_map)));

    p_eoi_miss_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rebuild_req && !dlv_valid && eoi_valid && !track_map[eoi_dest])
        |=> $stable(track_map));

    p_rebuild_enters_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rebuild_req) |=> busy);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend_count) <= NUM_DEST);

endmodule

bind eoi_coalesce_tracker eoi_tracker_checker #(
    .NUM_DEST (NUM_DEST),
    .DIDX_W   (DIDX_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .coalesced   (coalesced),
    .dlv_valid   (dlv_valid),
    .dlv_track   (dlv_track),
    .dlv_map     (dlv_map),
    .eoi_valid   (eoi_valid),
    .eoi_dest    (eoi_dest),
    .rebuild_req (rebuild_req),
    .pend_count  (pend_count),
    .track_map   (track_map)
);

// File: tb/eoi_coalesce_tracker_test.sv
module eoi_coalesce_tracker_test;

    localparam int N  = 16;
    localparam int VW = 8;
    localparam int DW = 4;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          edge_valid, edge_track, coalesced;
    logic          dlv_valid, dlv_track;
    logic [N-1:0]  dlv_map;
    logic [VW-1:0] dlv_vec;
    logic          eoi_valid;
    logic [DW-1:0] eoi_dest;
    logic [VW-1:0] eoi_vec;
    logic          sync_valid;
    logic [DW-1:0] sync_dest;
    logic          sync_pend;
    logic [VW-1:0] sync_vec;
    logic          rebuild_req;
    logic [N-1:0]  live_pend;
    logic [VW-1:0] live_vec;
    logic [CW-1:0] pend_count;
    logic          busy;

    // reference record
    logic          m_bit [N];
    logic [VW-1:0] m_vec [N];
    int            m_cnt;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    eoi_coalesce_tracker #(.NUM_DEST(N), .VEC_W(VW)) uut (
        .clk(clk), .rst_n(rst_n),
        .edge_valid(edge_valid), .edge_track(edge_track), .coalesced(coalesced),
        .dlv_valid(dlv_valid), .dlv_track(dlv_track), .dlv_map(dlv_map), .dlv_vec(dlv_vec),
        .eoi_valid(eoi_valid), .eoi_dest(eoi_dest), .eoi_vec(eoi_vec),
        .sync_valid(sync_valid), .sync_dest(sync_dest), .sync_pend(sync_pend), .sync_vec(sync_vec),
        .rebuild_req(rebuild_req), .live_pend(live_pend), .live_vec(live_vec),
        .pend_count(pend_count), .busy(busy)
    );

    function automatic int popc(logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic bit exp_coal(bit ev, bit tr, int cnt);
        return ev && tr && (cnt > 0);
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic quiet();
        edge_valid = 0; edge_track = 0;
        dlv_valid = 0; dlv_track = 0; dlv_map = '0; dlv_vec = '0;
        eoi_valid = 0; eoi_dest = '0; eoi_vec = '0;
        sync_valid = 0; sync_dest = '0; sync_pend = 0; sync_vec = '0;
        rebuild_req = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        quiet();
    endtask

    // reference updates, written from the requirements
    task automatic m_deliver(logic [N-1:0] map, logic [VW-1:0] v);
        for (int i = 0; i < N; i++) begin
            m_bit[i] = map[i];
            if (map[i]) m_vec[i] = v;
        end
        m_cnt = popc(map);
    endtask

    task automatic m_eoi(int d, logic [VW-1:0] v);
        if (m_bit[d] && m_vec[d] == v) begin
            m_bit[d] = 0;
            m_cnt--;
        end
    endtask

    task automatic m_sync(int d, bit p, logic [VW-1:0] v);
        if (p != m_bit[d]) begin
            m_bit[d] = p;
            if (p) begin m_vec[d] = v; m_cnt++; end
            else m_cnt--;
        end
    endtask

    task automatic op_deliver(bit tr, logic [N-1:0] map, logic [VW-1:0] v, string req);
        dlv_valid = 1; dlv_track = tr; dlv_map = map; dlv_vec = v;
        tick();
        if (tr) m_deliver(map, v);
        check(req, int'(pend_count), m_cnt);
    endtask

    task automatic op_eoi(int d, logic [VW-1:0] v, string req);
        eoi_valid = 1; eoi_dest = DW'(d); eoi_vec = v;
        tick();
        m_eoi(d, v);
        check(req, int'(pend_count), m_cnt);
    endtask

    task automatic op_sync(int d, bit p, logic [VW-1:0] v, string req);
        sync_valid = 1; sync_dest = DW'(d); sync_pend = p; sync_vec = v;
        tick();
        m_sync(d, p, v);
        check(req, int'(pend_count), m_cnt);
    endtask

    task automatic op_rebuild(logic [N-1:0] lp, logic [VW-1:0] lv);
        live_pend = lp; live_vec = lv; rebuild_req = 1;
        tick();
        check("R8 busy after request", int'(busy), 1);
        for (int k = 0; k < N; k++) begin
            // R8: strobes while busy are ignored
            eoi_valid = 1; eoi_dest = DW'(k); eoi_vec = lv;
            dlv_valid = 1; dlv_track = 1; dlv_map = '1; dlv_vec = 8'hEE;
            tick();
        end
        check("R8 busy on last scan cycle", int'(busy), 1);
        tick();
        check("R8 busy falls", int'(busy), 0);
        for (int i = 0; i < N; i++) begin
            m_bit[i] = lp[i];
            if (lp[i]) m_vec[i] = lv;
        end
        m_cnt = popc(lp);
        check("R8 rebuilt count", int'(pend_count), m_cnt);
    endtask

    task automatic probe_coal(bit ev, bit tr, string req);
        edge_valid = ev; edge_track = tr;
        #1;
        check(req, int'(coalesced), int'(exp_coal(ev, tr, m_cnt)));
        edge_valid = 0; edge_track = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        quiet();
        live_pend = '0; live_vec = '0;
        for (int i = 0; i < N; i++) begin m_bit[i] = 0; m_vec[i] = '0; end
        m_cnt = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check("R1 count", int'(pend_count), 0);
        check("R1 busy", int'(busy), 0);
        probe_coal(1, 1, "R1 coalesced");
        rst_n = 1;
        tick();

        // R3 / R2
        op_deliver(1, 16'h0005, 8'h31, "R3 tracked delivery count");
        probe_coal(1, 1, "R2 tracked assertion coalesced");
        probe_coal(1, 0, "R2 untracked never coalesced");
        // R6 / R5
        op_eoi(1, 8'h31, "R6 EOI from clear bit");
        op_eoi(0, 8'h32, "R6 EOI vector mismatch");
        op_eoi(0, 8'h31, "R5 matching EOI");
        op_eoi(0, 8'h31, "R6 repeated EOI");
        op_eoi(2, 8'h31, "R5 last EOI drains");
        probe_coal(1, 1, "R2 drained not coalesced");
        // R3 empty, R4
        op_deliver(1, 16'h0000, 8'h10, "R3 failed delivery zero");
        op_deliver(1, 16'h0300, 8'h22, "R3 second delivery");
        op_deliver(0, 16'hFFFF, 8'h55, "R4 untracked delivery ignored");
        op_eoi(8, 8'h55, "R4 untracked vector not recorded");
        op_eoi(8, 8'h22, "R3 vector recorded");
        op_eoi(9, 8'h22, "R5 drain");
        // R7
        op_sync(3, 1, 8'h44, "R7 resync sets");
        op_sync(3, 1, 8'h99, "R7 resync equal no change");
        op_eoi(3, 8'h99, "R7 vector kept on equal resync");
        op_eoi(3, 8'h44, "R7 recorded vector");
        op_sync(5, 0, 8'h00, "R7 resync clear bit equal");
        op_sync(6, 1, 8'h12, "R7 resync sets again");
        op_sync(6, 0, 8'h12, "R7 resync clears");
        // R9 priority
        dlv_valid = 1; dlv_track = 1; dlv_map = 16'h0003; dlv_vec = 8'h70;
        eoi_valid = 1; eoi_dest = 0; eoi_vec = 8'h70;
        sync_valid = 1; sync_dest = 7; sync_pend = 1; sync_vec = 8'h70;
        tick();
        m_deliver(16'h0003, 8'h70);
        check("R9 delivery beats EOI and resync", int'(pend_count), m_cnt);
        eoi_valid = 1; eoi_dest = 0; eoi_vec = 8'h70;
        sync_valid = 1; sync_dest = 7; sync_pend = 1; sync_vec = 8'h70;
        tick();
        m_eoi(0, 8'h70);
        check("R9 EOI beats resync", int'(pend_count), m_cnt);
        dlv_valid = 1; dlv_track = 0; dlv_map = '0;
        sync_valid = 1; sync_dest = 1; sync_pend = 0;
        tick();
        check("R9 untracked delivery still blocks resync", int'(pend_count), m_cnt);
        // R8 rebuild
        op_rebuild(16'hA50F, 8'h3C);
        probe_coal(1, 1, "R2 after rebuild");
        op_eoi(0, 8'h3C, "R8 rebuilt vector");
        op_eoi(15, 8'h3C, "R8 rebuilt vector top");
        op_rebuild(16'h0000, 8'h01);

        // constrained random mix
        for (int it = 0; it < 600; it++) begin
            int sel;
            int d;
            logic [VW-1:0] v;
            sel = int'($urandom_range(0, 99));
            d   = int'($urandom_range(0, N - 1));
            v   = VW'($urandom_range(0, 3)) | 8'h40;
            if (sel < 12) begin
                op_deliver($urandom_range(0, 3) != 0, N'($urandom), v, "R3 random delivery");
            end else if (sel < 60) begin
                if (m_bit[d] && $urandom_range(0, 2) != 0) v = m_vec[d];
                op_eoi(d, v, "R5 random EOI");
            end else if (sel < 97) begin
                op_sync(d, $urandom_range(0, 1) != 0, v, "R7 random resync");
            end else begin
                op_rebuild(N'($urandom), v);
            end
            probe_coal(1, $urandom_range(0, 1) != 0, "R2 random probe");
            check("R10 bound", int'(pend_count <= CW'(N)), 1);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule